// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block drives one DMA channel. Software loads a source address, a destination address and a unit count, then writes the control register with the enable bit set. From then on the channel waits for a request from the selected source: an automatic request, an external active-low request pin, or a strobe from an on-chip peripheral. When a request arrives it asks for the bus, waits for the grant, and moves one transfer unit. Each unit is a read from the source address followed by a write to the destination address on a simple command port. Every command is held until the memory side acknowledges it.

The unit size can be a byte, a halfword or a word. It can also be a 16-byte line, which is moved as four back-to-back word read/write pairs. A line counts as a single unit against the count. Both addresses advance by the unit size after each unit. In cycle-steal mode the bus request is dropped after every unit. In burst mode the bus is kept until the count runs out. When the count reaches zero the channel sets its end flag, releases the bus and stops. The interrupt output follows the flag gated by the interrupt enable. The channel restarts only after software clears the flag by writing 0 to it and loads a non-zero count.

The external pin can be level sampled or falling-edge sampled. That choice exists only on channel indices below a parameter limit. Peripheral strobes are always edge detected, and automatic requests need no sampling at all.

Top module: `dma_chan_seq`

## Requirements
- R1: Register select codes are 0 control, 1 count, 2 source address, 3 destination address, all read back on `cfg_rdata`. Control bits: 0 enable, 1 end flag, 3:2 request source, 4 pin-edge select, 5 burst, 7:6 size, 8 interrupt enable. Bits 31:9 read 0 and ignore writes. Writing 1 to the end flag does not set it.
- R2: The pin-edge select bit is stored only when `CHAN_INDEX` < `EDGE_SEL_CHANNELS`. On other channels it reads 0 whatever is written.
- R3: Size codes 00, 01 and 10 give one read/write pair per unit with `mem_size` equal to the code. Both addresses advance by 1, 2 or 4 per unit.
- R4: Size code 11 moves a unit as four word read/write pairs at offsets 0, 4, 8 and 12, each with `mem_size` = 10. The count drops by one and the addresses advance by 16 per unit.
- R5: With burst = 0, `bus_req` drops after every unit, so it falls once per unit.
- R6: With burst = 1, `bus_req` stays high from the first unit until the count is used up, so it falls once per run.
- R7: Source 01 with edge select 0 moves units only while `dreq_n` is low. While `dreq_n` stays high, nothing is issued.
- R8: Source 01 with edge select 1 moves one unit per falling edge of `dreq_n` in cycle-steal mode. A pin held low gives only one unit.
- R9: Source 10 moves one unit per rising edge of `periph_req` in cycle-steal mode, whatever the edge select bit holds.
- R10: Sources 00 and 11 run without any request and ignore `dreq_n` and `periph_req`.
- R11: When the count reaches zero, the end flag is set, the count reads 0, and `bus_req` and `mem_req` are low. `irq` is high exactly when the flag and the interrupt enable are both 1.
- R12: Writing the control register with bit 1 = 0 clears the flag. Reloading the count while the flag is still set starts nothing.
- R13: Each pair is a read (`mem_wr` = 0) at the source followed by a write (`mem_wr` = 1) at the destination. A command stays unchanged until `mem_ack`, and it is issued only while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data for `cfg_sel` |
| dreq_n | input | 1 | External request pin, active low |
| periph_req | input | 1 | On-chip peripheral request strobe |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_req | output | 1 | Memory command valid |
| mem_wr | output | 1 | Command is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Command address |
| mem_size | output | 2 | Access size code |
| mem_ack | input | 1 | Command accepted |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A wrong beat counter or a wrong address register shows up on `mem_addr` at the very next acknowledged command. So every logged access is compared with an address computed from the programmed base, the unit index and the beat. A count that is off by one shows when the run ends, as a wrong number of logged accesses or a flag that never rises. A request detector that is too eager or too lazy leaves the count register at the wrong value a few dozen cycles after a single pin or strobe event. Bus mode errors show in the number of `bus_req` falls per run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_LINE = 2'b11
   } xfer_size_e;

   typedef enum logic [1:0] {
      SRC_AUTO   = 2'b00,
      SRC_PIN    = 2'b01,
      SRC_PERIPH = 2'b10,
      SRC_AUTO2  = 2'b11
   } req_src_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUSREQ,
      ST_READ,
      ST_WRITE
   } seq_state_e;

   // Packed layout defines the control register bit positions (MSB first).
   typedef struct packed {
      logic       irq_en;
      xfer_size_e size;
      logic       burst;
      logic       edge_sel;
      req_src_e   src;
      logic       done;
      logic       en;
   } ctrl_t;

   localparam int CTRL_BITS  = $bits(ctrl_t);
   localparam int LINE_BYTES = 16;
   localparam int BEAT_BYTES = 4;
   localparam int LINE_BEATS = LINE_BYTES / BEAT_BYTES;
   localparam int BEAT_W     = $clog2(LINE_BEATS);

   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_SRC   = 2'd2;
   localparam logic [1:0] SEL_DST   = 2'd3;

   function automatic logic [4:0] unit_bytes(input xfer_size_e s);
      if (s == SZ_LINE) return 5'(LINE_BYTES);
      return 5'd1 << s;
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W            = 32,
   parameter int CNT_W             = 16,
   parameter int CFG_W             = 32,
   parameter int CHAN_INDEX        = 0,
   parameter int EDGE_SEL_CHANNELS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              unit_done,
   input  logic              set_done,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  count_q,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic              active,
   output logic              count_is_one,
   output logic              irq
);

   ctrl_t      wr_ctrl;
   logic       ctrl_wr;
   logic       en_q, burst_q, irq_en_q, done_q, edge_q;
   req_src_e   src_sel_q;
   xfer_size_e size_q;
   logic [ADDR_W-1:0] step;

   assign wr_ctrl = ctrl_t'(cfg_wdata[CTRL_BITS-1:0]);
   assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
   assign step    = ADDR_W'(unit_bytes(size_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         burst_q   <= 1'b0;
         irq_en_q  <= 1'b0;
         src_sel_q <= SRC_AUTO;
         size_q    <= SZ_BYTE;
      end else if (ctrl_wr) begin
         en_q      <= wr_ctrl.en;
         burst_q   <= wr_ctrl.burst;
         irq_en_q  <= wr_ctrl.irq_en;
         src_sel_q <= wr_ctrl.src;
         size_q    <= wr_ctrl.size;
      end
   end

   // End flag: hardware set wins over a software clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        done_q <= 1'b0;
      else if (set_done)                 done_q <= 1'b1;
      else if (ctrl_wr && !wr_ctrl.done) done_q <= 1'b0;
   end

   generate
      if (CHAN_INDEX < EDGE_SEL_CHANNELS) begin : g_edge_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       edge_q <= 1'b0;
            else if (ctrl_wr) edge_q <= wr_ctrl.edge_sel;
         end
      end else begin : g_no_edge_sel
         assign edge_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 count_q <= '0;
      else if (cfg_we && cfg_sel == SEL_COUNT)    count_q <= cfg_wdata[CNT_W-1:0];
      else if (unit_done)                         count_q <= count_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 src_q <= '0;
      else if (cfg_we && cfg_sel == SEL_SRC)      src_q <= cfg_wdata[ADDR_W-1:0];
      else if (unit_done)                         src_q <= src_q + step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 dst_q <= '0;
      else if (cfg_we && cfg_sel == SEL_DST)      dst_q <= cfg_wdata[ADDR_W-1:0];
      else if (unit_done)                         dst_q <= dst_q + step;
   end

   always_comb begin
      ctrl          = '0;
      ctrl.en       = en_q;
      ctrl.done     = done_q;
      ctrl.src      = src_sel_q;
      ctrl.edge_sel = edge_q;
      ctrl.burst    = burst_q;
      ctrl.size     = size_q;
      ctrl.irq_en   = irq_en_q;
   end

   assign active       = en_q && !done_q && (count_q != '0);
   assign count_is_one = (count_q == CNT_W'(1));
   assign irq          = done_q && irq_en_q;

   always_comb begin
      case (cfg_sel)
         SEL_CTRL:  cfg_rdata = CFG_W'(ctrl);
         SEL_COUNT: cfg_rdata = CFG_W'(count_q);
         SEL_SRC:   cfg_rdata = CFG_W'(src_q);
         default:   cfg_rdata = CFG_W'(dst_q);
      endcase
   end

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
   import dma_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     dreq_n,
   input  logic     periph_req,
   input  req_src_e src,
   input  logic     edge_sel,
   input  logic     active,
   input  logic     start,
   output logic     req_ok
);

   logic pin_s, pin_p, per_s, per_p;
   logic pin_pend, per_pend;
   logic pin_fall, per_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_s <= 1'b1;
         pin_p <= 1'b1;
         per_s <= 1'b0;
         per_p <= 1'b0;
      end else begin
         pin_s <= dreq_n;
         pin_p <= pin_s;
         per_s <= periph_req;
         per_p <= per_s;
      end
   end

   assign pin_fall = pin_p && !pin_s;
   assign per_rise = per_s && !per_p;

   // Edges are remembered only while the channel can use them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_pend <= 1'b0;
         per_pend <= 1'b0;
      end else if (!active || start) begin
         pin_pend <= 1'b0;
         per_pend <= 1'b0;
      end else begin
         pin_pend <= pin_pend || pin_fall;
         per_pend <= per_pend || per_rise;
      end
   end

   always_comb begin
      case (src)
         SRC_PIN:    req_ok = edge_sel ? (pin_pend || pin_fall) : !pin_s;
         SRC_PERIPH: req_ok = per_pend || per_rise;
         default:    req_ok = 1'b1;
      endcase
   end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              req_ok,
   input  logic              burst,
   input  logic              line_mode,
   input  logic              count_is_one,
   input  logic              bus_gnt,
   input  logic              mem_ack,
   output logic              start,
   output logic              unit_done,
   output logic              set_done,
   output logic              bus_req,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [BEAT_W-1:0] beat
);

   seq_state_e        st_q, st_d;
   logic [BEAT_W-1:0] beat_d;

   always_comb begin
      st_d      = st_q;
      beat_d    = beat;
      start     = 1'b0;
      unit_done = 1'b0;
      set_done  = 1'b0;
      case (st_q)
         ST_IDLE: if (active && req_ok) begin
            st_d  = ST_BUSREQ;
            start = 1'b1;
         end
         ST_BUSREQ: if (bus_gnt) st_d = ST_READ;
         ST_READ:   if (mem_ack) st_d = ST_WRITE;
         ST_WRITE: if (mem_ack) begin
            if (line_mode && beat != BEAT_W'(LINE_BEATS - 1)) begin
               beat_d = beat + 1'b1;
               st_d   = ST_READ;
            end else begin
               beat_d    = '0;
               unit_done = 1'b1;
               if (count_is_one) begin
                  set_done = 1'b1;
                  st_d     = ST_IDLE;
               end else if (burst) begin
                  st_d = ST_READ;
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         beat <= '0;
      end else begin
         st_q <= st_d;
         beat <= beat_d;
      end
   end

   assign bus_req = (st_q != ST_IDLE);
   assign mem_req = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_wr  = (st_q == ST_WRITE);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W            = 32,
   parameter int CNT_W             = 16,
   parameter int CFG_W             = 32,
   parameter int CHAN_INDEX        = 0,
   parameter int EDGE_SEL_CHANNELS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              dreq_n,
   input  logic              periph_req,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   input  logic              mem_ack,
   output logic              irq
);

   generate
      if (ADDR_W < 8 || ADDR_W > CFG_W) begin : g_bad_addr_w
         $error("dma_chan_seq: ADDR_W must lie in 8..CFG_W");
      end
      if (CNT_W < 2 || CNT_W > CFG_W) begin : g_bad_cnt_w
         $error("dma_chan_seq: CNT_W must lie in 2..CFG_W");
      end
      if (CFG_W < CTRL_BITS) begin : g_bad_cfg_w
         $error("dma_chan_seq: CFG_W too narrow for the control register");
      end
      if (CHAN_INDEX < 0 || EDGE_SEL_CHANNELS < 0) begin : g_bad_index
         $error("dma_chan_seq: channel index parameters must be non-negative");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [CNT_W-1:0]  count_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic              active, count_is_one;
   logic              req_ok, start, unit_done, set_done;
   logic              line_mode;
   logic [BEAT_W-1:0] beat;

   assign line_mode = (ctrl.size == SZ_LINE);

   dma_chan_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W),
      .CHAN_INDEX(CHAN_INDEX), .EDGE_SEL_CHANNELS(EDGE_SEL_CHANNELS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .unit_done(unit_done), .set_done(set_done),
      .ctrl(ctrl), .count_q(count_q), .src_q(src_q), .dst_q(dst_q),
      .active(active), .count_is_one(count_is_one), .irq(irq)
   );

   dma_req_detect u_req (
      .clk(clk), .rst_n(rst_n),
      .dreq_n(dreq_n), .periph_req(periph_req),
      .src(ctrl.src), .edge_sel(ctrl.edge_sel),
      .active(active), .start(start), .req_ok(req_ok)
   );

   dma_xfer_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .active(active), .req_ok(req_ok), .burst(ctrl.burst),
      .line_mode(line_mode), .count_is_one(count_is_one),
      .bus_gnt(bus_gnt), .mem_ack(mem_ack),
      .start(start), .unit_done(unit_done), .set_done(set_done),
      .bus_req(bus_req), .mem_req(mem_req), .mem_wr(mem_wr), .beat(beat)
   );

   assign mem_addr = (mem_wr ? dst_q : src_q) + ADDR_W'({beat, 2'b00});
   assign mem_size = line_mode ? SZ_WORD : ctrl.size;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              mem_req,
   input logic              mem_wr,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic              line_mode,
   input logic              burst,
   input logic              done,
   input logic              unit_done,
   input logic              set_done,
   input logic [CNT_W-1:0]  count_q,
   input logic              irq
);

   // R13: commands only under a held bus request
   assert_cmd_under_bus_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> bus_req);

   // R13: an unacknowledged command is held unchanged
   assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)));

   // R4: line units use word accesses
   assert_line_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && line_mode) |-> (mem_size == 2'b10));

   // R5: cycle steal releases the bus after a unit
   assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && !burst) |=> !bus_req);

   // R6: burst keeps the bus between units
   assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && burst && !set_done) |=> bus_req);

   // R11: stopped while the end flag is set
   assert_stop_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bus_req && !mem_req));

   // R11: no unit completes on an empty count
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      unit_done |-> (count_q != '0));

   // R11: interrupt only with the end flag
   assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_req(bus_req), .mem_req(mem_req), .mem_wr(mem_wr), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .mem_size(mem_size),
   .line_mode(line_mode), .burst(ctrl.burst), .done(ctrl.done),
   .unit_done(unit_done), .set_done(set_done), .count_q(count_q), .irq(irq)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;
   localparam int CFG_W  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CFG_W-1:0] cfg_rdata;
   logic dreq_n = 1'b1;
   logic periph_req = 1'b0;
   logic bus_req, bus_gnt = 1'b0;
   logic mem_req, mem_wr, mem_ack = 1'b0;
   logic [ADDR_W-1:0] mem_addr;
   logic [1:0] mem_size;
   logic irq;

   // second instance on a channel without the edge-select bit
   logic hi_we = 1'b0;
   logic [CFG_W-1:0] hi_rdata;
   logic hi_bus_req, hi_mem_req, hi_mem_wr, hi_irq;
   logic [ADDR_W-1:0] hi_mem_addr;
   logic [1:0] hi_mem_size;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic [31:0] log_addr [64];
   logic        log_wr   [64];
   logic [1:0]  log_size [64];
   int n_log = 0;
   int n_rel = 0;
   logic bus_prev = 1'b0;
   int ack_wait = 0;

   always #2 clk = ~clk;

   dma_chan_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .CHAN_INDEX(0))
   u_dma_chan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq_n(dreq_n),
      .periph_req(periph_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_ack(mem_ack), .irq(irq)
   );

   dma_chan_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .CHAN_INDEX(2))
   u_hi (
      .clk(clk), .rst_n(rst_n), .cfg_we(hi_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(hi_rdata), .dreq_n(1'b1),
      .periph_req(1'b0), .bus_req(hi_bus_req), .bus_gnt(1'b0),
      .mem_req(hi_mem_req), .mem_wr(hi_mem_wr), .mem_addr(hi_mem_addr),
      .mem_size(hi_mem_size), .mem_ack(1'b0), .irq(hi_irq)
   );

   // Bus and memory responder, active on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         bus_gnt = bus_req;
         if (bus_prev && !bus_req) n_rel++;
         bus_prev = bus_req;
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (ack_wait == 0) begin
               mem_ack = 1'b1;
               if (n_log < 64) begin
                  log_addr[n_log] = mem_addr;
                  log_wr[n_log]   = mem_wr;
                  log_size[n_log] = mem_size;
               end
               n_log++;
               ack_wait = $urandom_range(0, 2);
            end else begin
               ack_wait--;
            end
         end
      end
   end

   function automatic logic [31:0] mk_ctrl(input bit en, input logic [1:0] src,
                                           input bit edge_s, input bit burst,
                                           input logic [1:0] sz, input bit ie);
      return {23'd0, ie, sz, burst, edge_s, src, 1'b0, en};
   endfunction

   function automatic int ubytes(input logic [1:0] sz);
      return (sz == 2'b11) ? 16 : (1 << sz);
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] sa, input logic [31:0] da,
                                            input logic [1:0] sz, input int k);
      int p = k / 2;
      int off = (sz == 2'b11) ? ((p / 4) * 16 + (p % 4) * 4) : p * ubytes(sz);
      return ((k % 2) ? da : sa) + off;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      cfg_sel = sel;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_done(input int max, output bit ok);
      logic [31:0] d;
      ok = 0;
      for (int i = 0; i < max; i++) begin
         cfg_read(2'd0, d);
         if (d[1]) begin ok = 1; break; end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_log(input string tag, input logic [31:0] sa, input logic [31:0] da,
                            input int cnt, input logic [1:0] sz);
      int nexp = cnt * ((sz == 2'b11) ? 8 : 2);
      check({tag, " access count"}, n_log, nexp);
      for (int k = 0; k < nexp && k < n_log && k < 64; k++) begin
         check({tag, " addr"}, log_addr[k], exp_addr(sa, da, sz, k));
         check({tag, " R13 rd/wr order"}, {31'd0, log_wr[k]}, (k % 2));
         check({tag, " size"}, {30'd0, log_size[k]}, (sz == 2'b11) ? 2 : sz);
      end
   endtask

   task automatic run_case(input string tag, input logic [31:0] sa, input logic [31:0] da,
                           input int cnt, input logic [1:0] sz, input bit burst,
                           input bit ie, input logic [1:0] src);
      bit ok;
      logic [31:0] d;
      n_log = 0; n_rel = 0;
      cfg_write(2'd2, sa);
      cfg_write(2'd3, da);
      cfg_write(2'd1, cnt);
      cfg_write(2'd0, mk_ctrl(1, src, 0, burst, sz, ie));
      wait_done(3000, ok);
      check({tag, " R11 end flag set"}, ok, 1);
      idle(2);
      check_log({tag, (sz == 2'b11) ? " R4" : " R3"}, sa, da, cnt, sz);
      check({tag, burst ? " R6 bus releases" : " R5 bus releases"}, n_rel, burst ? 1 : cnt);
      cfg_read(2'd1, d); check({tag, " R11 count zero"}, d, 0);
      cfg_read(2'd2, d); check({tag, " R3 src advance"}, d, sa + cnt * ubytes(sz));
      cfg_read(2'd3, d); check({tag, " R3 dst advance"}, d, da + cnt * ubytes(sz));
      check({tag, " R11 irq"}, irq, ie);
      check({tag, " R11 bus idle"}, {bus_req, mem_req}, 0);
      cfg_write(2'd0, 32'd0);
      cfg_read(2'd0, d);
      check({tag, " R12 flag cleared"}, d[1], 0);
      check({tag, " R11 irq low"}, irq, 0);
   endtask

   initial begin
      logic [31:0] d;
      bit ok;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      cfg_read(2'd0, d); check("R1 reset ctrl", d, 0);
      cfg_read(2'd1, d); check("R1 reset count", d, 0);
      check("R11 reset outputs", {bus_req, mem_req, irq}, 0);

      // R1: reserved bits and end flag not writable to 1
      cfg_write(2'd0, 32'hFFFF_FFFF);
      cfg_read(2'd0, d); check("R1 ctrl readback", d, 32'h0000_01FD);
      idle(10);
      check("R11 no run with zero count", {bus_req, mem_req}, 0);
      cfg_write(2'd0, 32'd0);

      // R2: edge select absent on a high channel
      @(negedge clk); cfg_sel = 2'd0; cfg_wdata = 32'h0000_0010; hi_we = 1'b1;
      @(negedge clk); hi_we = 1'b0; #1;
      check("R2 high channel edge bit", hi_rdata, 32'd0);
      cfg_write(2'd0, 32'h0000_0010);
      cfg_read(2'd0, d); check("R2 low channel edge bit", d, 32'h10);
      cfg_write(2'd0, 32'd0);

      // directed transfers
      run_case("R10 byte steal", 32'h1000, 32'h2000, 3, 2'b00, 0, 1, 2'b00);
      run_case("R3 half burst", 32'h3002, 32'h4000, 4, 2'b01, 1, 0, 2'b00);
      run_case("R3 word steal", 32'h5000, 32'h6004, 2, 2'b10, 0, 1, 2'b11);
      run_case("R4 line burst", 32'h7000, 32'h8010, 2, 2'b11, 1, 1, 2'b00);
      run_case("R4 line steal", 32'h9000, 32'hA000, 1, 2'b11, 0, 0, 2'b00);

      // R7: level sampled pin
      n_log = 0;
      cfg_write(2'd2, 32'h100); cfg_write(2'd3, 32'h200); cfg_write(2'd1, 3);
      cfg_write(2'd0, mk_ctrl(1, 2'b01, 0, 0, 2'b00, 0));
      idle(40);
      check("R7 pin high no access", n_log, 0);
      dreq_n = 1'b0;
      wait_done(1000, ok);
      check("R7 level run completes", ok, 1);
      check("R7 level access count", n_log, 6);
      dreq_n = 1'b1;
      cfg_write(2'd0, 32'd0);

      // R8: falling-edge sampled pin
      n_log = 0;
      cfg_write(2'd1, 3);
      cfg_write(2'd0, mk_ctrl(1, 2'b01, 1, 0, 2'b00, 0));
      dreq_n = 1'b0;
      idle(40);
      cfg_read(2'd1, d); check("R8 one unit per edge", d, 2);
      check("R8 accesses after one edge", n_log, 2);
      for (int e = 0; e < 2; e++) begin
         dreq_n = 1'b1; idle(3); dreq_n = 1'b0; idle(40);
      end
      cfg_read(2'd0, d); check("R8 done after three edges", d[1], 1);
      dreq_n = 1'b1;
      cfg_write(2'd0, 32'd0);

      // R9: peripheral strobe, edge select bit left 0
      n_log = 0;
      cfg_write(2'd1, 3);
      cfg_write(2'd0, mk_ctrl(1, 2'b10, 0, 0, 2'b01, 0));
      periph_req = 1'b1;
      idle(40);
      cfg_read(2'd1, d); check("R9 held strobe gives one unit", d, 2);
      for (int e = 0; e < 2; e++) begin
         periph_req = 1'b0; idle(3); periph_req = 1'b1; idle(40);
      end
      cfg_read(2'd0, d); check("R9 done after three strobes", d[1], 1);
      periph_req = 1'b0;

      // R12: reload without clearing the flag starts nothing
      n_log = 0;
      cfg_write(2'd1, 2);
      idle(30);
      check("R12 no restart with flag set", n_log, 0);
      cfg_write(2'd0, mk_ctrl(1, 2'b00, 0, 0, 2'b00, 0));
      wait_done(1000, ok);
      check("R12 restart after clear", n_log, 4);
      cfg_write(2'd0, 32'd0);

      // constrained random runs with auto request
      for (int r = 0; r < 8; r++) begin
         logic [1:0] sz = 2'($urandom_range(0, 3));
         int cnt = $urandom_range(1, 4);
         bit bm = 1'($urandom_range(0, 1));
         bit ie = 1'($urandom_range(0, 1));
         logic [31:0] sa = $urandom & 32'hFFFF_FFF0;
         logic [31:0] da = $urandom & 32'hFFFF_FFF0;
         dreq_n = 1'($urandom_range(0, 1));
         run_case("R10 random", sa, da, cnt, sz, bm, ie, 2'b00);
      end
      dreq_n = 1'b1;

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule